// File: doc/BRIEF.md
# Tiered Priority Burst-Locked Port Arbiter

This block decides which of several bus masters may drive a single memory-controller slave port. Masters sit in fixed tiers. A screen-refresh master is in the top tier. A system-bus master is in the second tier and an instruction/data-bus master is in the third. The bottom tier is shared by `NUM_GEN` general masters, such as DMA engines, and these are served in rotation. The tier order is wired into the logic, and no input can change it.

Once a master holds the port, it keeps it until it marks its final beat. No request can take the port away in the middle of a burst, including one from the top tier. Arbitration is performed only when the port is idle, or in the cycle where the owner marks its final beat. The winner's grant appears after the next clock edge.

Each master declares a burst length with its request. A sticky error flag reports either of two faults: a granted master declared a length above `MAX_BURST`, or a master held the port for more than `MAX_BURST` beats. A counter reports how long the refresh master has been kept waiting. With this counter, the worst-case stall can be checked against the burst limit.

Top module: `tier_arbiter`

## Requirements
- R1: After reset, all grants are low, `burst_err` is low and `disp_wait` is zero. The rotation pointer of the bottom tier starts at general master 0 (port index 3).
- R2: Port indices are 0 for refresh, 1 for system bus, 2 for instruction/data bus, and 3 to 3+NUM_GEN-1 for the general masters. At an arbitration point the lowest index with a request wins. A general master can win only when indices 0 to 2 are all idle.
- R3: `gnt` is one-hot or all zero. A grant that starts at an arbitration point goes only to a master whose request was high in that cycle.
- R4: An arbitration point is a cycle where no grant is held, or where the owner's `last` bit is high. The result shows on `gnt` after the next rising edge. If nothing is requested at that point, `gnt` becomes zero.
- R5: While the owner's `last` is low, `gnt` does not change, whatever other masters request, including the refresh master.
- R6: Within the bottom tier, the search starts at the pointer and wraps around. When a general master wins, the pointer moves to the general master after it. When a higher tier wins, the pointer does not move.
- R7: `burst_err` goes high on the edge that would begin beat MAX_BURST+1 of one grant. A burst of exactly MAX_BURST beats does not raise it. Once set, it stays high until reset.
- R8: `burst_err` also goes high on the grant edge when the winner's `blen` field is greater than MAX_BURST. A value equal to MAX_BURST does not raise it.
- R9: `disp_wait` counts up on each edge where `req[0]` is high and `gnt[0]` is low, saturating at its maximum. On any other edge it returns to zero.
- R10: If no burst exceeds MAX_BURST beats, `disp_wait` never goes above MAX_BURST.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | 3+NUM_GEN | Request per master, one bit per port index |
| blen | input | (3+NUM_GEN)*LEN_W | Declared burst length per master; field i sits at bits i*LEN_W and up |
| last | input | 3+NUM_GEN | Final-beat marker per master, used only from the current owner |
| gnt | output | 3+NUM_GEN | Registered grant, one-hot or zero |
| disp_wait | output | WAIT_W | Cycles the refresh master has waited for its current request |
| burst_err | output | 1 | Sticky flag: burst too long, or declared length above limit |

## Verification
The hardest case to reach is the worst-case refresh stall. The refresh request must arrive in the first beat of a general master's burst that runs to exactly `MAX_BURST` beats. If it arrives earlier, refresh simply wins arbitration. If it arrives later, the measured wait is shorter. The stimulus grants a general master from idle, raises the refresh request on the following clock, and holds `last` low until beat `MAX_BURST`. The stimulus then checks two things: the wait count equals the limit when refresh is granted, and the error flag stays low. A second case is the pointer that must stay still when a higher tier wins. The stimulus first walks the bottom tier to a known pointer, then inserts a system-bus grant. The next general choice then shows whether the pointer moved.

// File: rtl/tier_arbiter.sv
module tier_arbiter #(
  parameter int NUM_GEN   = 4,
  parameter int MAX_BURST = 8,
  parameter int LEN_W     = 5,
  parameter int WAIT_W    = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [3+NUM_GEN-1:0]           req,
  input  logic [(3+NUM_GEN)*LEN_W-1:0]   blen,
  input  logic [3+NUM_GEN-1:0]           last,
  output logic [3+NUM_GEN-1:0]           gnt,
  output logic [WAIT_W-1:0]              disp_wait,
  output logic                           burst_err
);
  localparam int N     = 3 + NUM_GEN;
  localparam int IDX_W = $clog2(N);
  localparam int GI_W  = (NUM_GEN > 1) ? $clog2(NUM_GEN) : 1;
  localparam int CNT_W = $clog2(MAX_BURST + 2);

  logic             busy;
  logic [IDX_W-1:0] owner;
  logic [CNT_W-1:0] beats;
  logic [GI_W-1:0]  rr_ptr;
  logic [GI_W-1:0]  gen_pick;
  logic             gen_hit;
  logic [IDX_W-1:0] win;
  logic             win_valid;
  logic             rearb;

  assign rearb     = !busy || last[owner];
  assign win_valid = |req;
  assign gnt       = busy ? ({{(N-1){1'b0}}, 1'b1} << owner) : '0;

  always_comb begin : pick_gen
    int idx;
    gen_hit  = 1'b0;
    gen_pick = '0;
    for (int k = 0; k < NUM_GEN; k++) begin
      idx = (int'(rr_ptr) + k) % NUM_GEN;
      if (!gen_hit && req[3 + idx]) begin
        gen_hit  = 1'b1;
        gen_pick = GI_W'(idx);
      end
    end
  end

  always_comb begin
    if (req[0])      win = IDX_W'(0);
    else if (req[1]) win = IDX_W'(1);
    else if (req[2]) win = IDX_W'(2);
    else             win = IDX_W'(3 + int'(gen_pick));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      owner     <= '0;
      beats     <= '0;
      rr_ptr    <= '0;
      burst_err <= 1'b0;
    end else if (rearb) begin
      busy  <= win_valid;
      owner <= win;
      beats <= CNT_W'(1);
      if (win_valid && !req[0] && !req[1] && !req[2] && gen_hit)
        rr_ptr <= GI_W'((int'(gen_pick) + 1) % NUM_GEN);
      if (win_valid && (int'(blen[int'(win)*LEN_W +: LEN_W]) > MAX_BURST))
        burst_err <= 1'b1;
    end else begin
      if (int'(beats) <= MAX_BURST) beats <= beats + 1'b1;
      if (int'(beats) >= MAX_BURST) burst_err <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 disp_wait <= '0;
    else if (req[0] && !gnt[0]) begin
      if (disp_wait != '1) disp_wait <= disp_wait + 1'b1;
    end else                    disp_wait <= '0;
  end
endmodule

module tier_arbiter_chk #(
  parameter int NUM_GEN   = 4,
  parameter int MAX_BURST = 8,
  parameter int LEN_W     = 5,
  parameter int WAIT_W    = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [3+NUM_GEN-1:0]         req,
  input logic [(3+NUM_GEN)*LEN_W-1:0] blen,
  input logic [3+NUM_GEN-1:0]         last,
  input logic [3+NUM_GEN-1:0]         gnt,
  input logic [WAIT_W-1:0]            disp_wait,
  input logic                         burst_err
);
  logic arb_pt;
  assign arb_pt = (gnt == '0) || (|(gnt & last));

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_has_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_pt |=> ((gnt & ~$past(req)) == '0));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && req == '0) |=> gnt == '0);
  p_no_preempt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !(|(gnt & last))) |=> gnt == $past(gnt));
  p_disp_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && req[0]) |=> gnt[0]);
  p_sys_second_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_pt && req[1] && !req[0]) |=> gnt[1]);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    burst_err |=> burst_err);
  p_wait_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_err |-> int'(disp_wait) <= MAX_BURST);
  p_wait_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    gnt[0] |=> disp_wait == '0);
endmodule

bind tier_arbiter tier_arbiter_chk #(
  .NUM_GEN(NUM_GEN), .MAX_BURST(MAX_BURST), .LEN_W(LEN_W), .WAIT_W(WAIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .blen(blen), .last(last),
  .gnt(gnt), .disp_wait(disp_wait), .burst_err(burst_err)
);

// File: tb/tier_arbiter_tb.sv
`timescale 1ns/1ps
module tier_arbiter_tb;
  localparam int NG = 4, N = 7, MAXB = 8, LW = 5, WW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic             rst_n;
  logic [N-1:0]     req, last, gnt;
  logic [N*LW-1:0]  blen;
  logic [WW-1:0]    disp_wait;
  logic             burst_err;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  tier_arbiter #(.NUM_GEN(NG), .MAX_BURST(MAXB), .LEN_W(LW), .WAIT_W(WW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .blen(blen), .last(last),
    .gnt(gnt), .disp_wait(disp_wait), .burst_err(burst_err));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic adv();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; last = '0; blen = {N{5'd4}};
    repeat (3) adv();
    rst_n = 1'b1;
    adv();
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 gnt after reset", gnt, 0);
    chk("R1 err after reset", burst_err, 0);
    chk("R1 wait after reset", disp_wait, 0);
    last = '1; req = 7'b1111000;
    adv(); chk("R1 first general pick", gnt, 7'h08);
    req = '0;
    adv(); chk("R4 idle after last beat", gnt, 0);
  endtask

  task automatic t_priority();
    do_reset();
    last = '1; req = 7'h7F;
    adv(); chk("R2 refresh wins", gnt, 7'h01);
    req = 7'h7E; adv(); chk("R2 system bus next", gnt, 7'h02);
    req = 7'h7C; adv(); chk("R2 instr/data next", gnt, 7'h04);
    req = 7'h78; adv(); chk("R6 general 0", gnt, 7'h08);
    adv(); chk("R6 general 1", gnt, 7'h10);
    adv(); chk("R6 general 2", gnt, 7'h20);
    adv(); chk("R6 general 3", gnt, 7'h40);
    adv(); chk("R6 wrap to general 0", gnt, 7'h08);
    req = 7'b0000010; adv(); chk("R2 system bus alone", gnt, 7'h02);
    req = 7'b0101000; adv(); chk("R6 pointer kept over higher tier", gnt, 7'h20);
    req = '0; adv(); chk("R4 no request gives zero grant", gnt, 0);
  endtask

  task automatic t_hold();
    do_reset();
    last = '0; req = 7'b0010000;
    adv(); chk("R4 grant next edge", gnt, 7'h10);
    req = 7'b0010011;
    adv(); chk("R5 refresh cannot preempt", gnt, 7'h10);
    chk("R9 wait one", disp_wait, 1);
    adv(); chk("R5 still held", gnt, 7'h10);
    chk("R9 wait two", disp_wait, 2);
    last = 7'b0010000;
    adv(); chk("R2 refresh after last beat", gnt, 7'h01);
    chk("R9 wait three at grant", disp_wait, 3);
    last = '0; req = 7'b0000011;
    adv(); chk("R5 refresh burst held", gnt, 7'h01);
    chk("R9 wait cleared", disp_wait, 0);
    last = 7'b0000001; req = 7'b0000010;
    adv(); chk("R2 system bus after refresh", gnt, 7'h02);
  endtask

  task automatic t_worst();
    do_reset();
    last = '0; blen = {N{5'd8}}; req = 7'b0001000;
    adv(); chk("R4 general granted", gnt, 7'h08);
    chk("R8 length equal to limit is fine", burst_err, 0);
    req = 7'b0001001;
    repeat (7) adv();
    chk("R5 held through beat limit", gnt, 7'h08);
    last = 7'b0001000;
    adv(); chk("R10 refresh granted", gnt, 7'h01);
    chk("R10 worst wait equals limit", disp_wait, MAXB);
    chk("R7 exact limit no error", burst_err, 0);
  endtask

  task automatic t_overrun();
    do_reset();
    last = '0; req = 7'b0000100;
    adv(); chk("R4 instr/data granted", gnt, 7'h04);
    repeat (7) adv();
    chk("R7 no error at beat limit", burst_err, 0);
    adv(); chk("R7 error on extra beat", burst_err, 1);
    req = '0; last = '1;
    adv(); chk("R4 released", gnt, 0);
    chk("R7 error sticky", burst_err, 1);
  endtask

  task automatic t_blen();
    do_reset();
    last = '1;
    blen[5*LW +: LW] = 5'd9;
    req = 7'b0100000;
    adv(); chk("R8 grant with long length", gnt, 7'h20);
    chk("R8 declared length above limit", burst_err, 1);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_hold();
    t_worst();
    t_overrun();
    t_blen();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule